// File: doc/BRIEF.md
# Ultrasonic transmit burst generator

This block produces the drive burst for one ultrasonic time-of-flight measurement. A one-cycle `go` strobe from the measurement sequencer starts a burst. The block divides its clock down to the transducer's resonant frequency by a programmable power of two. It then emits a programmed number of square pulses on `tx_drive` and raises a `start_pulse` timing reference that rises in the same cycle as the first drive edge. When the burst is over, the block reports this with a one-cycle `burst_done`.

Two optional shaping features change the waveform. The first is a 180-degree phase inversion from a chosen pulse index onward; enabling it removes one pulse from the burst. The second is a damping tail that holds the drive high for one extra pulse period after the last pulse. Damping is not allowed together with the inversion, and it is not allowed with the maximum pulse count. In those combinations the block drops the damping request, so the waveform stays deterministic. The configuration is captured when `go` is accepted. Later changes to the inputs do not affect a burst that is already running.

The control is a four-state machine:
- IDLE waits for an accepted `go`.
- PULSE emits the pulses.
- DAMP holds the damping tail.
- DONE flags completion for one cycle.

The transitions are:
- IDLE to PULSE when `go` is accepted and the effective pulse count is nonzero.
- IDLE to DONE when `go` is accepted and the effective count is zero.
- PULSE to DAMP at the end of the last period, when damping is valid.
- PULSE to DONE at the end of the last period, when damping is not valid.
- DAMP to DONE at the end of the tail period.
- DONE to IDLE unconditionally.

Top module: `tx_burst_gen`

## Requirements
- R1: After reset `tx_drive`, `start_pulse` and `burst_done` are low, and the block waits in IDLE.
- R2: With divider code c, one pulse period T1 is 2^(c+1) clock cycles. Each normal pulse drives high for the first 2^c cycles of its period and low for the rest.
- R3: An accepted `go` (sampled at clock edge e) makes `tx_drive` and `start_pulse` reflect the burst from the cycle after e. The burst has N pulse periods with no drive afterwards, where N is `pulse_num` (0 to 31).
- R4: `start_pulse` stays high for min(N,3) x T1 cycles from the first burst cycle. It never rises when N is 0.
- R5: The inversion is active when `flip_pos` is not 31 and `flip_pos` < N. In that case the burst has N-1 periods. Pulse index i (counted from 0) with i >= `flip_pos` is inverted: low for the first half of its period and high for the second.
- R6: With `damp_en` set and the damping valid, the last pulse period is followed by one T1 of constant high drive. Damping is valid when there is no active inversion and N is neither 0 nor 31.
- R7: If damping is requested together with an active inversion, or with N = 31, it is ignored. The drive then ends exactly as without damping.
- R8: `burst_done` is high for exactly one cycle, the first cycle after the last drive cycle (the cycle after `go` when the burst is empty). The drive is low in that cycle.
- R9: `go` is ignored while a burst runs or while `start_pulse` is high. Configuration changes after acceptance do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Burst start strobe |
| div_code | input | CODE_W (3) | Divider code c, T1 = 2^(c+1) cycles |
| pulse_num | input | CNT_W (5) | Requested pulse count N |
| flip_pos | input | CNT_W (5) | Inversion index, 31 disables |
| damp_en | input | 1 | Damping request |
| tx_drive | output | 1 | Transducer drive waveform |
| start_pulse | output | 1 | Timing reference pulse |
| burst_done | output | 1 | One-cycle completion flag |

## Verification
The hardest cases to reach from the ports are the combinations where the shaping rules interact. Examples are an inversion index equal to N-1 (one pulse removed but none inverted), damping requested alongside an inversion, and the 31-pulse limit. A single stimulus also has to show that a second `go` and new configuration values arriving mid-burst are both ignored. The bench sweeps every combination of several divider codes, pulse counts (including 0, 1, 2, 3 and 31), inversion positions and damping settings. It compares every output cycle against a waveform computed arithmetically from the requirements. A subset of bursts is disturbed with a second `go` and a changed configuration a few cycles after start.

// File: rtl/tx_burst_pkg.sv
package tx_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_DAMP  = 2'd2,
        ST_DONE  = 2'd3
    } burst_state_t;

endpackage

// File: rtl/tx_burst_cfg_decode.sv
module tx_burst_cfg_decode #(
    parameter int CODE_W  = 3,
    parameter int CNT_W   = 5,
    parameter int START_W = 10
) (
    input  logic [CODE_W-1:0]  div_code,
    input  logic [CNT_W-1:0]   pulse_num,
    input  logic [CNT_W-1:0]   flip_pos,
    input  logic               damp_req,
    output logic               shift_act,
    output logic [CNT_W-1:0]   eff_num,
    output logic               damp_ok,
    output logic [START_W-1:0] start_len
);
    localparam logic [CNT_W-1:0] SHIFT_OFF = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] START_CAP = CNT_W'(3);

    logic [CNT_W-1:0] start_mult;

    always_comb begin
        shift_act  = (flip_pos != SHIFT_OFF) && (flip_pos < pulse_num);
        eff_num    = shift_act ? (pulse_num - CNT_W'(1)) : pulse_num;
        damp_ok    = damp_req && !shift_act &&
                     (pulse_num != SHIFT_OFF) && (pulse_num != '0);
        start_mult = (pulse_num >= START_CAP) ? START_CAP : pulse_num;
        start_len  = START_W'(start_mult) << (START_W'(div_code) + START_W'(1));
    end

endmodule

// File: rtl/tx_burst_phase_timer.sv
module tx_burst_phase_timer #(
    parameter int CODE_W = 3,
    parameter int PH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    output logic              first_half,
    output logic              period_end
);
    logic [PH_W-1:0] cyc_q;
    logic [PH_W:0]   half_len;
    logic [PH_W:0]   last_cyc;

    always_comb begin
        half_len   = (PH_W+1)'(1) << code;
        last_cyc   = (half_len << 1) - (PH_W+1)'(1);
        first_half = {1'b0, cyc_q} < half_len;
        period_end = {1'b0, cyc_q} == last_cyc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (clr) begin
            cyc_q <= '0;
        end else if (en) begin
            cyc_q <= period_end ? '0 : cyc_q + PH_W'(1);
        end
    end

endmodule

// File: rtl/tx_burst_start_timer.sv
module tx_burst_start_timer #(
    parameter int START_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [START_W-1:0] len,
    output logic               active
);
    logic [START_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= len;
        end else if (left_q != '0) begin
            left_q <= left_q - START_W'(1);
        end
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/tx_burst_gen.sv
module tx_burst_gen
    import tx_burst_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CODE_W-1:0] div_code,
    input  logic [CNT_W-1:0]  pulse_num,
    input  logic [CNT_W-1:0]  flip_pos,
    input  logic              damp_en,
    output logic              tx_drive,
    output logic              start_pulse,
    output logic              burst_done
);
    localparam int PH_W    = 2**CODE_W;
    localparam int START_W = PH_W + 2;

    burst_state_t state_q, state_d;

    logic               dec_act, dec_damp;
    logic [CNT_W-1:0]   dec_eff;
    logic [START_W-1:0] dec_start;

    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  eff_q, pos_q, idx_q;
    logic              act_q, damp_q;

    logic accept, first_half, period_end, run_en, last_pulse, inverted;

    tx_burst_cfg_decode #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W),
        .START_W(START_W)
    ) decode_i (
        .div_code (div_code),
        .pulse_num(pulse_num),
        .flip_pos (flip_pos),
        .damp_req (damp_en),
        .shift_act(dec_act),
        .eff_num  (dec_eff),
        .damp_ok  (dec_damp),
        .start_len(dec_start)
    );

    assign accept = go && (state_q == ST_IDLE) && !start_pulse;
    assign run_en = (state_q == ST_PULSE) || (state_q == ST_DAMP);

    tx_burst_phase_timer #(
        .CODE_W(CODE_W),
        .PH_W  (PH_W)
    ) phase_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .en        (run_en),
        .code      (code_q),
        .first_half(first_half),
        .period_end(period_end)
    );

    tx_burst_start_timer #(
        .START_W(START_W)
    ) start_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .len   (dec_start),
        .active(start_pulse)
    );

    // Configuration captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            eff_q  <= '0;
            pos_q  <= '1;
            act_q  <= 1'b0;
            damp_q <= 1'b0;
        end else if (accept) begin
            code_q <= div_code;
            eff_q  <= dec_eff;
            pos_q  <= flip_pos;
            act_q  <= dec_act;
            damp_q <= dec_damp;
        end
    end

    // Pulse index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= '0;
        end else if ((state_q == ST_PULSE) && period_end) begin
            idx_q <= idx_q + CNT_W'(1);
        end
    end

    assign last_pulse = ({1'b0, idx_q} + (CNT_W+1)'(1)) == {1'b0, eff_q};
    assign inverted   = act_q && (idx_q >= pos_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (dec_eff == '0) ? ST_DONE : ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (period_end && last_pulse) begin
                    state_d = damp_q ? ST_DAMP : ST_DONE;
                end
            end
            ST_DAMP: begin
                if (period_end) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        tx_drive   = 1'b0;
        burst_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  tx_drive = 1'b0;
            ST_PULSE: tx_drive = first_half ^ inverted;
            ST_DAMP:  tx_drive = 1'b1;
            ST_DONE:  burst_done = 1'b1;
            default:  tx_drive = 1'b0;
        endcase
    end

endmodule

// File: rtl/tx_burst_chk.sv
module tx_burst_chk
    import tx_burst_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic [CNT_W-1:0] flip_pos,
    input logic             tx_drive,
    input logic             start_pulse,
    input logic             burst_done,
    input burst_state_t     state_q
);

    // R8: completion flag lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_done);

    // R8: drive is quiet while completion is flagged
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> !tx_drive);

    // R8: completion follows a running burst or an accepted empty burst
    p_done_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> ($past(state_q) != ST_IDLE || $past(go)));

    // R3: the reference pulse only rises in response to go
    p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_pulse) |-> $past(go));

    // R3, R5: first drive cycle is high unless inversion starts at index 0
    p_start_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_pulse) |-> (tx_drive || $past(flip_pos) == '0));

endmodule

bind tx_burst_gen tx_burst_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .flip_pos   (flip_pos),
    .tx_drive   (tx_drive),
    .start_pulse(start_pulse),
    .burst_done (burst_done),
    .state_q    (state_q)
);

// File: tb/tx_burst_gen_tb_top.sv
module tx_burst_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [2:0] div_code = 3'd2;
    logic [4:0] pulse_num = 5'd5;
    logic [4:0] flip_pos = 5'd31;
    logic       damp_en = 1'b0;
    logic       tx_drive, start_pulse, burst_done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tx_burst_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .div_code   (div_code),
        .pulse_num  (pulse_num),
        .flip_pos   (flip_pos),
        .damp_en    (damp_en),
        .tx_drive   (tx_drive),
        .start_pulse(start_pulse),
        .burst_done (burst_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    task automatic run_burst(input int c, input int n, input int p, input bit d, input bit disturb);
        int  h, t1, e, len, w, tend, idx;
        bit  act, dok, ex_tx, ex_st, ex_dn;
        string tag;
        h    = 1 << c;
        t1   = 2 * h;
        act  = (p != 31) && (p < n);
        e    = act ? n - 1 : n;
        dok  = d && !act && (n != 31) && (n != 0);
        len  = e * t1 + (dok ? t1 : 0);
        w    = ((n >= 3) ? 3 : n) * t1;
        tend = ((len > w) ? len : w) + 3;
        @(negedge clk);
        div_code  = 3'(c);
        pulse_num = 5'(n);
        flip_pos  = 5'(p);
        damp_en   = d;
        go        = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int t = 0; t < tend; t++) begin
            if (t < e * t1) begin
                idx   = t / t1;
                ex_tx = ((t % t1) < h) ^ (act && idx >= p);
                tag   = act ? "R5" : "R2";
            end else if (t < len) begin
                ex_tx = 1'b1;
                tag   = "R6";
            end else begin
                ex_tx = 1'b0;
                tag   = (d && !dok) ? "R7" : "R3";
            end
            if (disturb) tag = "R9";
            ex_st = (t < w);
            ex_dn = (t == len);
            check(tx_drive == ex_tx, tag, int'(tx_drive), int'(ex_tx));
            check(start_pulse == ex_st, disturb ? "R9" : "R4", int'(start_pulse), int'(ex_st));
            check(burst_done == ex_dn, disturb ? "R9" : "R8", int'(burst_done), int'(ex_dn));
            if (disturb && t == 2) begin
                go        = 1'b1;
                div_code  = 3'(c ^ 1);
                pulse_num = 5'(n + 1);
                flip_pos  = 5'd1;
                damp_en   = ~d;
            end else begin
                go = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int counts[7] = '{0, 1, 2, 3, 4, 7, 31};
        int poss[4]   = '{31, 0, 2, 5};
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_drive == 1'b0, "R1", int'(tx_drive), 0);
        check(start_pulse == 1'b0, "R1", int'(start_pulse), 0);
        check(burst_done == 1'b0, "R1", int'(burst_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_drive == 1'b0 && start_pulse == 1'b0 && burst_done == 1'b0, "R1",
              int'({tx_drive, start_pulse, burst_done}), 0);
        for (int c = 0; c < 3; c++) begin
            for (int ni = 0; ni < 7; ni++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    for (int d = 0; d < 2; d++) begin
                        run_burst(c, counts[ni], poss[pi], d[0], 1'b0);
                    end
                end
            end
        end
        // Boundary inversion indices: last index and index 1
        run_burst(1, 6, 5, 1'b0, 1'b0);
        run_burst(1, 6, 1, 1'b1, 1'b0);
        // Largest divider
        run_burst(7, 2, 31, 1'b1, 1'b0);
        // R9: mid-burst go and configuration change
        run_burst(1, 5, 31, 1'b0, 1'b1);
        run_burst(0, 7, 3, 1'b1, 1'b1);
        run_burst(2, 4, 31, 1'b1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule